// File: doc/BRIEF.md
# Firmware Image Stream Verifier

This block checks a firmware image while it streams past, one 32-bit word per valid beat, with a flag on the final word. The first word identifies the image's byte order. From then on every word of a big-endian image is byte-reversed before use, and a little-endian image passes through unchanged. A five-word header carries the identifying word, a segment/sequence word, a version word, and the byte sizes of the instruction section and the data section. The block checks that both sizes are whole words and that the stream length agrees with them. It also keeps a running 32-bit sum and compares it with the final word of the stream.

While the stream is accepted, the converted payload words are presented on the output for a memory writer. Each word carries a section tag (instruction or data) and a word address that starts at zero in each section. A one-cycle done pulse ends each image. It comes with either a pass flag or an error code. After done, the block ignores input until the next start pulse.

Top module: `fwImageVerifier`

## Requirements
- R1: After reset, and until the first start pulse, done, pass, outValid are low and errCode is 0; beats arriving while not armed produce no output and no done.
- R2: A first word of 0xfe0101fe selects little-endian (words pass unchanged); 0xfe1010fe selects big-endian, in which every later word has its four bytes reversed (bits 7:0 swap with 31:24, bits 15:8 with 23:16) before any use.
- R3: Any other first word ends the image with errCode 1, signalled on that first beat.
- R4: If the instruction byte size (header word 3) or the data byte size (header word 4) has either of its two low bits set, the image ends with errCode 2 on the beat of header word 4.
- R5: The stream must hold exactly 5 + imem/4 + dmem/4 + 1 words, with last set on the final word. Last on any earlier word, or a final checksum word without last, ends the image with errCode 2 on that beat.
- R6: Instruction payload words follow the header and come out with outIsData=0, then data payload words with outIsData=1. outAddr is 0 for the first word of each section and rises by one per word. Each output appears in the cycle after its input beat.
- R7: The last word is compared with the 32-bit wrapping sum of all five header words and all payload words, each after byte-order conversion. A match gives pass=1 with errCode 0; a mismatch gives errCode 3.
- R8: done is high for exactly one cycle per image, in the cycle after the deciding beat; pass and errCode hold their values until the next start.
- R9: After done, no output word is produced and further beats are dropped until start. A start pulse in the middle of an image abandons it. The beat presented in the start cycle is ignored.
- R10: Cycles with inValid low neither advance the word count nor change the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms the verifier for a new image |
| inValid | input | 1 | Input beat valid |
| inData | input | 32 | Raw image word |
| inLast | input | 1 | Marks the final word of the stream |
| outValid | output | 1 | Converted payload word valid |
| outIsData | output | 1 | 0 = instruction section, 1 = data section |
| outAddr | output | ADDR_W (16) | Word address within the section |
| outWord | output | 32 | Byte-order-converted payload word |
| done | output | 1 | One-cycle end-of-image pulse |
| pass | output | 1 | Image accepted |
| errCode | output | 2 | 0 none, 1 bad magic, 2 bad size/length, 3 bad checksum |

## Verification
A wrong byte-order flag corrupts every following output word and the checksum result in the next cycle. This makes big-endian images with known patterns the quickest probe. A word counter or section boundary that is off by one shows up as a misplaced section tag, an address that does not restart at zero, or a length error on the wrong beat. The scoreboard catches each of these on the first wrong output. The bench also sends streams that are too short, too long, or misaligned, plus streams that restart in the middle. A state machine that fails to stop would then show stray outputs or a second done pulse.

// File: rtl/fwVerPkg.sv
package fwVerPkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] MAGIC_LE = 32'hfe0101fe;
  localparam logic [WORD_W-1:0] MAGIC_BE = 32'hfe1010fe;
  localparam int HDR_WORDS = 5;
  localparam int HDR_IMEM_IDX = 3;
  localparam int HDR_DMEM_IDX = 4;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_MAGIC = 2'd1,
    ERR_SIZE  = 2'd2,
    ERR_SUM   = 2'd3
  } errCodeT;

  typedef struct packed {
    logic clear;
    logic setBigEnd;
    logic capImem;
    logic capDmem;
    logic accum;
    logic emit;
    logic emitData;
    logic firstOfSec;
  } dpStrobeT;
endpackage

// File: rtl/fwVerDatapath.sv
module fwVerDatapath
  import fwVerPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          stb,
  input  logic [WORD_W-1:0] inData,
  output logic              magicLe,
  output logic              magicBe,
  output logic [WORD_W-1:0] convWord,
  output logic [WORD_W-1:0] imemBytes,
  output logic [WORD_W-1:0] dmemBytes,
  output logic              sumOk,
  output logic              outValid,
  output logic              outIsData,
  output logic [ADDR_W-1:0] outAddr,
  output logic [WORD_W-1:0] outWord
);
  localparam int BYTES = WORD_W / 8;

  logic              bigEnd;
  logic [WORD_W-1:0] swapped;
  logic [WORD_W-1:0] sumAcc;
  logic [ADDR_W-1:0] addrCnt;
  logic [ADDR_W-1:0] addrUse;

  for (genvar b = 0; b < BYTES; b++) begin : g_swap
    assign swapped[8*b +: 8] = inData[8*(BYTES-1-b) +: 8];
  end

  assign magicLe  = (inData == MAGIC_LE);
  assign magicBe  = (inData == MAGIC_BE);
  assign convWord = bigEnd ? swapped : inData;
  assign sumOk    = (sumAcc == convWord);
  assign addrUse  = stb.firstOfSec ? '0 : addrCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bigEnd    <= 1'b0;
      sumAcc    <= '0;
      imemBytes <= '0;
      dmemBytes <= '0;
      addrCnt   <= '0;
      outValid  <= 1'b0;
      outIsData <= 1'b0;
      outAddr   <= '0;
      outWord   <= '0;
    end else begin
      outValid <= stb.emit;
      if (stb.clear) begin
        bigEnd    <= 1'b0;
        sumAcc    <= '0;
        imemBytes <= '0;
        dmemBytes <= '0;
        addrCnt   <= '0;
      end else begin
        if (stb.setBigEnd) bigEnd <= 1'b1;
        if (stb.accum) sumAcc <= sumAcc + convWord;
        if (stb.capImem) imemBytes <= convWord;
        if (stb.capDmem) dmemBytes <= convWord;
        if (stb.emit) begin
          addrCnt   <= addrUse + 1'b1;
          outIsData <= stb.emitData;
          outAddr   <= addrUse;
          outWord   <= convWord;
        end
      end
    end
  end

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid) && outIsData == $past(outIsData))
      |-> outAddr == $past(outAddr) + 1'b1);

  // R6
  sec_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIsData && $past(outValid) && !$past(outIsData))
      |-> outAddr == '0);
endmodule

// File: rtl/fwVerCtrl.sv
module fwVerCtrl
  import fwVerPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic              inLast,
  input  logic              magicLe,
  input  logic              magicBe,
  input  logic [WORD_W-1:0] convWord,
  input  logic [WORD_W-1:0] imemBytes,
  input  logic [WORD_W-1:0] dmemBytes,
  input  logic              sumOk,
  output dpStrobeT          stb,
  output logic              done,
  output logic              pass,
  output errCodeT           errCode
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HALT} stateT;

  stateT            state;
  logic [CNT_W-1:0] wordIdx;
  logic [CNT_W-1:0] payIdx;
  logic [CNT_W-1:0] imemWords;
  logic [CNT_W-1:0] secEnd;
  logic             finishNow;
  logic             nextPass;
  errCodeT          nextErr;

  assign payIdx    = wordIdx - CNT_W'(HDR_WORDS);
  assign imemWords = CNT_W'(imemBytes[WORD_W-1:2]);
  assign secEnd    = imemWords + CNT_W'(dmemBytes[WORD_W-1:2]);

  always_comb begin
    stb       = '0;
    finishNow = 1'b0;
    nextPass  = 1'b0;
    nextErr   = ERR_NONE;
    if (start) begin
      stb.clear = 1'b1;
    end else if (state == ST_RUN && inValid) begin
      if (wordIdx < CNT_W'(HDR_WORDS)) begin
        stb.accum = 1'b1;
        if (wordIdx == '0) begin
          if (!(magicLe || magicBe)) begin
            finishNow = 1'b1;
            nextErr   = ERR_MAGIC;
          end else begin
            stb.setBigEnd = magicBe;
          end
        end
        if (wordIdx == CNT_W'(HDR_IMEM_IDX)) stb.capImem = 1'b1;
        if (wordIdx == CNT_W'(HDR_DMEM_IDX)) begin
          stb.capDmem = 1'b1;
          if (imemBytes[1:0] != 2'b00 || convWord[1:0] != 2'b00) begin
            finishNow = 1'b1;
            nextErr   = ERR_SIZE;
          end
        end
        if (inLast && !finishNow) begin
          finishNow = 1'b1;
          nextErr   = ERR_SIZE;
        end
      end else if (payIdx < secEnd) begin
        stb.accum = 1'b1;
        if (inLast) begin
          finishNow = 1'b1;
          nextErr   = ERR_SIZE;
        end else begin
          stb.emit       = 1'b1;
          stb.emitData   = (payIdx >= imemWords);
          stb.firstOfSec = (payIdx == '0) || (payIdx == imemWords);
        end
      end else begin
        finishNow = 1'b1;
        if (!inLast)      nextErr  = ERR_SIZE;
        else if (!sumOk)  nextErr  = ERR_SUM;
        else              nextPass = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
      done    <= 1'b0;
      pass    <= 1'b0;
      errCode <= ERR_NONE;
    end else begin
      done <= 1'b0;
      if (start) begin
        state   <= ST_RUN;
        wordIdx <= '0;
        pass    <= 1'b0;
        errCode <= ERR_NONE;
      end else if (state == ST_RUN && inValid) begin
        wordIdx <= wordIdx + 1'b1;
        if (finishNow) begin
          state   <= ST_HALT;
          done    <= 1'b1;
          pass    <= nextPass;
          errCode <= nextErr;
        end
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT && !start) |=> ($stable(errCode) && $stable(pass)));

  // R7
  pass_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> errCode == ERR_NONE);
endmodule

// File: rtl/fwImageVerifier.sv
module fwImageVerifier
  import fwVerPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic [31:0]       inData,
  input  logic              inLast,
  output logic              outValid,
  output logic              outIsData,
  output logic [ADDR_W-1:0] outAddr,
  output logic [31:0]       outWord,
  output logic              done,
  output logic              pass,
  output logic [1:0]        errCode
);
  dpStrobeT          stb;
  logic              magicLe;
  logic              magicBe;
  logic [WORD_W-1:0] convWord;
  logic [WORD_W-1:0] imemBytes;
  logic [WORD_W-1:0] dmemBytes;
  logic              sumOk;
  errCodeT           errInt;

  assign errCode = errInt;

  fwVerCtrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .inLast(inLast),
    .magicLe(magicLe), .magicBe(magicBe), .convWord(convWord),
    .imemBytes(imemBytes), .dmemBytes(dmemBytes), .sumOk(sumOk),
    .stb(stb), .done(done), .pass(pass), .errCode(errInt)
  );

  fwVerDatapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData),
    .magicLe(magicLe), .magicBe(magicBe), .convWord(convWord),
    .imemBytes(imemBytes), .dmemBytes(dmemBytes), .sumOk(sumOk),
    .outValid(outValid), .outIsData(outIsData), .outAddr(outAddr), .outWord(outWord)
  );

  // R9
  no_emit_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && done));

  // R9
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !outValid);

  // R8
  done_after_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(inValid));
endmodule

// File: tb/fwImageVerifier_tb_top.sv
module fwImageVerifier_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inLast = 1'b0;
  logic        outValid, outIsData, done, pass;
  logic [15:0] outAddr;
  logic [31:0] outWord;
  logic [1:0]  errCode;

  always #4 clk = ~clk;

  fwImageVerifier dut_i (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .inData(inData),
    .inLast(inLast), .outValid(outValid), .outIsData(outIsData), .outAddr(outAddr),
    .outWord(outWord), .done(done), .pass(pass), .errCode(errCode)
  );

  typedef struct {
    logic        isData;
    logic [15:0] addr;
    logic [31:0] word;
  } itemT;

  itemT        expQ[$];
  logic [31:0] img[$];
  int          nRun = 0;
  int          nFail = 0;
  int          doneCnt = 0;
  string       curReq = "R6";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R9", "unexpected payload word", outWord, 32'h0);
        end else begin
          itemT it;
          it = expQ.pop_front();
          chk(outIsData == it.isData && outAddr == it.addr && outWord == it.word,
              curReq, "payload {tag,addr,word}",
              {outIsData, 7'd0, outAddr[7:0], outWord[15:0]},
              {it.isData, 7'd0, it.addr[7:0], it.word[15:0]});
        end
      end
      if (done) doneCnt++;
    end
  end

  task automatic build(input bit be, input int ni, input int nd,
                       input int extraImem, input bit badSum, input bit pushExp);
    logic [31:0] l [$];
    logic [31:0] sum;
    img.delete();
    l.push_back(be ? 32'hfe1010fe : 32'hfe0101fe);
    l.push_back(32'h0002_0001);
    l.push_back(32'h0105_0300 + ni);
    l.push_back(ni * 4 + extraImem);
    l.push_back(nd * 4);
    for (int i = 0; i < ni; i++) begin
      logic [31:0] w;
      w = 32'h1122_3300 + i * 32'h0101_0001 + (be ? 32'h4000_0000 : 0);
      l.push_back(w);
      if (pushExp) expQ.push_back('{1'b0, 16'(i), w});
    end
    for (int i = 0; i < nd; i++) begin
      logic [31:0] w;
      w = 32'hc0de_0a00 + i * 32'h0003_0107 + (be ? 32'h0100_0000 : 0);
      l.push_back(w);
      if (pushExp) expQ.push_back('{1'b1, 16'(i), w});
    end
    sum = '0;
    foreach (l[k]) sum = sum + l[k];
    if (badSum) sum = sum + 32'd1;
    l.push_back(sum);
    foreach (l[k]) img.push_back(be ? swap32(l[k]) : l[k]);
  endtask

  task automatic drive(input int n, input int lastPos, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData  = img[i];
      inLast  = (i == lastPos);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        inValid = 1'b0;
        inLast  = 1'b0;
        inData  = 32'hdead_beef;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  task automatic startImg();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finishCheck(input string req, input bit expPass, input int expErr);
    repeat (3) @(negedge clk);
    chk(doneCnt == 1, req, "done pulse count", doneCnt, 1);
    chk(pass == expPass, req, "pass", pass, expPass);
    chk(errCode == expErr, req, "errCode", errCode, expErr);
    chk(expQ.size() == 0, req, "payload words left unseen", expQ.size(), 0);
    expQ.delete();
    doneCnt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!done && !pass && !outValid && errCode == 0, "R1", "reset outputs",
        {done, pass, outValid, errCode}, 0);
    // R1: beats before any start are ignored
    build(1'b0, 2, 1, 0, 1'b0, 1'b0);
    drive(img.size(), img.size() - 1, 0);
    repeat (3) @(negedge clk);
    chk(doneCnt == 0 && errCode == 0, "R1", "idle beats gave done", doneCnt, 0);

    // R2 R6 R7: little-endian image
    curReq = "R6";
    startImg();
    build(1'b0, 3, 2, 0, 1'b0, 1'b1);
    drive(img.size(), img.size() - 1, 0);
    finishCheck("R7", 1'b1, 0);

    // R9: after done, beats without start are dropped, result holds
    build(1'b0, 1, 1, 0, 1'b1, 1'b0);
    drive(img.size(), img.size() - 1, 0);
    repeat (3) @(negedge clk);
    chk(doneCnt == 0, "R9", "done after halt", doneCnt, 0);
    chk(pass == 1'b1 && errCode == 0, "R8", "result held", {pass, errCode}, 3'b100);

    // R2 R10: big-endian image with gaps
    curReq = "R2";
    startImg();
    build(1'b1, 2, 3, 0, 1'b0, 1'b1);
    drive(img.size(), img.size() - 1, 2);
    finishCheck("R2", 1'b1, 0);

    // R3: bad magic, remainder dropped
    curReq = "R3";
    startImg();
    build(1'b0, 1, 1, 0, 1'b0, 1'b0);
    img[0] = 32'hfe0110fe;
    drive(img.size(), img.size() - 1, 0);
    finishCheck("R3", 1'b0, 1);

    // R4: misaligned instruction size
    curReq = "R4";
    startImg();
    build(1'b0, 2, 1, 2, 1'b0, 1'b0);
    drive(img.size(), img.size() - 1, 0);
    finishCheck("R4", 1'b0, 2);

    // R5: stream too short (last on third instruction word)
    curReq = "R5";
    startImg();
    build(1'b0, 4, 2, 0, 1'b0, 1'b1);
    expQ = expQ[0:1];
    drive(8, 7, 0);
    finishCheck("R5", 1'b0, 2);

    // R5: checksum word without last, extra words dropped
    startImg();
    build(1'b0, 1, 1, 0, 1'b0, 1'b1);
    img.push_back(32'h1234_5678);
    img.push_back(32'h0);
    drive(img.size(), img.size() - 1, 0);
    finishCheck("R5", 1'b0, 2);

    // R7: checksum mismatch on a big-endian image
    curReq = "R7";
    startImg();
    build(1'b1, 2, 2, 0, 1'b1, 1'b1);
    drive(img.size(), img.size() - 1, 1);
    finishCheck("R7", 1'b0, 3);

    // R5 R7: empty sections
    startImg();
    build(1'b0, 0, 0, 0, 1'b0, 1'b1);
    drive(img.size(), img.size() - 1, 0);
    finishCheck("R5", 1'b1, 0);

    // R6: no instruction words, data addresses from zero
    curReq = "R6";
    startImg();
    build(1'b1, 0, 3, 0, 1'b0, 1'b1);
    drive(img.size(), img.size() - 1, 0);
    finishCheck("R6", 1'b1, 0);

    // R9: restart in mid image
    curReq = "R9";
    startImg();
    build(1'b0, 3, 1, 0, 1'b0, 1'b1);
    expQ = expQ[0:0];
    drive(6, -1, 0);
    repeat (2) @(negedge clk);
    chk(doneCnt == 0 && expQ.size() == 0, "R9", "partial image output",
        doneCnt + expQ.size(), 0);
    // start cycle carries a beat that must be ignored
    @(negedge clk);
    start = 1'b1; inValid = 1'b1; inData = 32'h0bad_0bad;
    @(negedge clk);
    start = 1'b0; inValid = 1'b0;
    build(1'b0, 1, 2, 0, 1'b0, 1'b1);
    drive(img.size(), img.size() - 1, 0);
    finishCheck("R9", 1'b1, 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule